// File: doc/BRIEF.md
# Slave Port Arbiter

This block decides which of several bus masters owns the single port of one shared slave. It looks at each master's request, its 2-bit priority and the state of its burst, and holds the winner in a register whose decoded form is a one-hot grant. A grant stays with its owner until a re-arbitration point. Such a point occurs when the owner drops its request, when it marks the final beat of a burst, when a per-master chunk size is reached inside an undefined-length incrementing burst, or when a per-slave cycle budget runs out.

When nobody requests, the slave either disconnects or parks on a master. It can park on the master it served last or on a fixed master. A parked master that starts requesting owns the port in that same cycle. A disconnected slave grants one cycle after the request appears. Address decoding and data steering are outside the block. Burst ends and beats reach it as plain strobes from the owning master.

Top module: `slvport_arb`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `gnt_o` is all zero and `preconn_o` is low.
- R2: At most one bit of `gnt_o` is set in any cycle.
- R3: At a re-arbitration point, the requesting master with the numerically largest priority wins. Master i's priority is `prio_i[PW*i +: PW]`.
- R4: Among requesting masters of equal top priority, the winner is the first one found counting upward, wrapping, from the master granted most recently. After reset the count starts at master 0.
- R5: Chunk code 1 (`ulbt_i[3*i +: 3]`) makes every beat of an undefined-length burst a re-arbitration point.
- R6: Chunk codes 2 to 7 make the beat numbered 2^code within the current tenure a re-arbitration point (4, 8, 16, 32, 64, 128 beats). A waiting equal-priority master then takes over on the following cycle.
- R7: Chunk code 0 breaks an undefined-length burst only at its 256th beat (the 1 KB word boundary) or at slot expiry.
- R8: For a burst that is not undefined-length (`undef_i` low), the chunk code is ignored. Only a beat carrying `last_i` ends it.
- R9: A nonzero `slot_lim_i` of L makes the L-th cycle of a tenure a re-arbitration point. A value of 0 switches the limit off.
- R10: When a re-arbitration point arrives and only the owner requests, the owner keeps the grant with no idle cycle.
- R11: With park mode 0 (or the unused code 3), an idle slave drops all grants. A new request is granted on the cycle after it appears.
- R12: With park mode 1, an idle slave stays granted to the master granted most recently. That master's request is served in the same cycle it rises.
- R13: With park mode 2, an idle slave is granted to master `park_fixed_i`. If that number is not below NM, the slave disconnects.
- R14: `preconn_o` is high exactly when a grant is held by a master whose request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NM | Per-master request |
| undef_i | input | NM | Per-master flag: current burst is undefined-length incrementing |
| beat_i | input | NM | Per-master beat-complete strobe |
| last_i | input | NM | Per-master final-beat strobe |
| prio_i | input | NM*PW | Packed priorities, PW bits per master |
| ulbt_i | input | NM*3 | Packed chunk codes, 3 bits per master |
| slot_lim_i | input | SLW | Maximum tenure in cycles, 0 = unlimited |
| park_mode_i | input | 2 | Idle policy: 0 none, 1 last, 2 fixed, 3 none |
| park_fixed_i | input | FXW | Master number for fixed parking |
| gnt_o | output | NM | One-hot grant |
| preconn_o | output | 1 | Slave connected to a non-requesting master |

## Verification
The bench builds the arbiter with NM=4, PW=2, SLW=9 and FXW=4. With only four masters, every one of the 256 priority assignments can be paired with every one of the 15 non-empty request masks. The round-robin pointer carries over from each case to the next, so the priority ordering and the tie-breaking are covered completely. The same small setup makes it cheap to walk all eight chunk codes up to the 256-beat boundary and to try several slot limits. It also visits every park mode, including a fixed master number beyond the populated range.

// File: rtl/sparb_pkg.sv
package sparb_pkg;

  localparam int ULB_W       = 3;
  localparam int BOUND_BEATS = 256;
  localparam int BCNT_W      = $clog2(BOUND_BEATS) + 1;

  typedef enum logic [1:0] {
    PARK_NONE  = 2'd0,
    PARK_LAST  = 2'd1,
    PARK_FIXED = 2'd2,
    PARK_RSVD  = 2'd3
  } park_e;

  // beats per chunk for an undefined-length burst
  function automatic logic [BCNT_W-1:0] chunk_beats(input logic [ULB_W-1:0] code);
    logic [BCNT_W-1:0] n;
    case (code)
      3'd0:    n = BCNT_W'(BOUND_BEATS);
      3'd1:    n = BCNT_W'(1);
      default: n = BCNT_W'(1) << code;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/sparb_pick.sv
module sparb_pick #(
  parameter int NM = 12,
  parameter int PW = 2,
  parameter int IW = 4
) (
  input  logic [NM-1:0]    req,
  input  logic [NM*PW-1:0] prio,
  input  logic [IW-1:0]    last,
  output logic             win_vld,
  output logic [IW-1:0]    win_idx
);

  logic [PW-1:0] top_pri;
  logic [NM-1:0] cand;

  // highest priority among requesters
  always_comb begin
    top_pri = '0;
    for (int i = 0; i < NM; i++) begin
      if (req[i] && (prio[i*PW +: PW] > top_pri)) top_pri = prio[i*PW +: PW];
    end
  end

  always_comb begin
    for (int i = 0; i < NM; i++) begin
      cand[i] = req[i] && (prio[i*PW +: PW] == top_pri);
    end
  end

  // rotate from the master after the last one served
  always_comb begin
    logic found;
    found   = 1'b0;
    win_idx = '0;
    for (int k = 1; k <= NM; k++) begin
      if (!found && cand[IW'((int'(last) + k) % NM)]) begin
        win_idx = IW'((int'(last) + k) % NM);
        found   = 1'b1;
      end
    end
    win_vld = found;
  end

endmodule

// File: rtl/sparb_tenure.sv
module sparb_tenure
  import sparb_pkg::*;
#(
  parameter int SLW = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             restart,
  input  logic             beat,
  input  logic             last,
  input  logic             undef,
  input  logic [ULB_W-1:0] code,
  input  logic [SLW-1:0]   slot_lim,
  output logic             brk,
  output logic             expire
);

  logic [BCNT_W-1:0] beat_q, beat_d;
  logic [SLW-1:0]    slot_q, slot_d;
  logic              beat_en, slot_en;
  logic              beat_hit, chunk_hit, lim_on;

  assign beat_hit  = active && beat;
  assign chunk_hit = undef && ((beat_q + BCNT_W'(1)) == chunk_beats(code));
  assign brk       = beat_hit && (last || chunk_hit);

  assign lim_on = (slot_lim != '0);
  assign expire = active && lim_on &&
                  (({1'b0, slot_q} + (SLW+1)'(1)) >= {1'b0, slot_lim});

  // next state
  always_comb begin
    beat_en = restart || beat_hit;
    beat_d  = restart ? '0 : beat_q + BCNT_W'(1);
    slot_en = restart || (active && lim_on);
    slot_d  = restart ? '0 : slot_q + SLW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
      slot_q <= '0;
    end else begin
      if (beat_en) beat_q <= beat_d;
      if (slot_en) slot_q <= slot_d;
    end
  end

endmodule

// File: rtl/slvport_arb.sv
module slvport_arb
  import sparb_pkg::*;
#(
  parameter int NM  = 12,
  parameter int PW  = 2,
  parameter int SLW = 9,
  parameter int FXW = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NM-1:0]       req_i,
  input  logic [NM-1:0]       undef_i,
  input  logic [NM-1:0]       beat_i,
  input  logic [NM-1:0]       last_i,
  input  logic [NM*PW-1:0]    prio_i,
  input  logic [NM*ULB_W-1:0] ulbt_i,
  input  logic [SLW-1:0]      slot_lim_i,
  input  logic [1:0]          park_mode_i,
  input  logic [FXW-1:0]      park_fixed_i,
  output logic [NM-1:0]       gnt_o,
  output logic                preconn_o
);

  localparam int IW = (NM > 1) ? $clog2(NM) : 1;

  logic [IW-1:0] own_q, own_d, last_q, last_d;
  logic          vld_q, vld_d, ever_q, ever_d;
  logic          own_req, arb_pt, brk, expire;
  logic          win_vld;
  logic [IW-1:0] win_idx;
  logic          fixed_ok;

  assign own_req  = vld_q && req_i[own_q];
  assign arb_pt   = !own_req || brk || expire;
  assign fixed_ok = (int'(park_fixed_i) < NM);

  sparb_pick #(.NM(NM), .PW(PW), .IW(IW)) u_pick (
    .req     (req_i),
    .prio    (prio_i),
    .last    (last_q),
    .win_vld (win_vld),
    .win_idx (win_idx)
  );

  sparb_tenure #(.SLW(SLW)) u_ten (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (own_req),
    .restart  (arb_pt),
    .beat     (beat_i[own_q]),
    .last     (last_i[own_q]),
    .undef    (undef_i[own_q]),
    .code     (ulbt_i[own_q*ULB_W +: ULB_W]),
    .slot_lim (slot_lim_i),
    .brk      (brk),
    .expire   (expire)
  );

  // next owner
  always_comb begin
    own_d  = own_q;
    vld_d  = vld_q;
    last_d = last_q;
    ever_d = ever_q;
    if (win_vld) begin
      own_d  = win_idx;
      vld_d  = 1'b1;
      last_d = win_idx;
      ever_d = 1'b1;
    end else begin
      case (park_e'(park_mode_i))
        PARK_LAST: begin
          own_d = last_q;
          vld_d = ever_q;
        end
        PARK_FIXED: begin
          own_d = IW'(park_fixed_i);
          vld_d = fixed_ok;
        end
        default: vld_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q  <= '0;
      vld_q  <= 1'b0;
      last_q <= IW'(NM-1);
      ever_q <= 1'b0;
    end else if (arb_pt) begin
      own_q  <= own_d;
      vld_q  <= vld_d;
      last_q <= last_d;
      ever_q <= ever_d;
    end
  end

  for (genvar g = 0; g < NM; g++) begin : g_gnt
    assign gnt_o[g] = vld_q && (own_q == IW'(g));
  end

  assign preconn_o = vld_q && !req_i[own_q];

endmodule

// File: rtl/sparb_chk.sv
module sparb_chk #(
  parameter int NM  = 12,
  parameter int SLW = 9,
  parameter int FXW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NM-1:0]  req_i,
  input logic [NM-1:0]  beat_i,
  input logic [SLW-1:0] slot_lim_i,
  input logic [1:0]     park_mode_i,
  input logic [FXW-1:0] park_fixed_i,
  input logic [NM-1:0]  gnt_o,
  input logic           preconn_o
);

  assert_gnt_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));

  assert_hold_nolimit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(gnt_o & req_i)) && !(|(gnt_o & beat_i)) && (slot_lim_i == '0))
    |=> $stable(gnt_o));

  assert_park_none_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((park_mode_i == 2'd0) && (req_i == '0)) |=> (gnt_o == '0));

  assert_park_last_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ((park_mode_i == 2'd1) && ($past(park_mode_i) == 2'd1) && (req_i == '0) &&
     ($past(req_i) == '0) && (|gnt_o)) |=> $stable(gnt_o));

  assert_park_fixed_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ((park_mode_i == 2'd2) && (req_i == '0) && (int'(park_fixed_i) < NM))
    |=> (gnt_o == (NM'(1) << $past(park_fixed_i))));

  assert_preconn_R14: assert property (@(posedge clk) disable iff (!rst_n)
    preconn_o |-> ((|gnt_o) && !(|(gnt_o & req_i))));

endmodule

bind slvport_arb sparb_chk #(.NM(NM), .SLW(SLW), .FXW(FXW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_i        (req_i),
  .beat_i       (beat_i),
  .slot_lim_i   (slot_lim_i),
  .park_mode_i  (park_mode_i),
  .park_fixed_i (park_fixed_i),
  .gnt_o        (gnt_o),
  .preconn_o    (preconn_o)
);

// File: tb/sim_slvport_arb.sv
module sim_slvport_arb;

  localparam int NM  = 4;
  localparam int PW  = 2;
  localparam int SLW = 9;
  localparam int FXW = 4;

  logic            clk;
  logic            rst_n;
  logic [NM-1:0]   req, undef, beat, lst;
  logic [NM*PW-1:0] prio;
  logic [NM*3-1:0] ulbt;
  logic [SLW-1:0]  slot_lim;
  logic [1:0]      pmode;
  logic [FXW-1:0]  pfix;
  logic [NM-1:0]   gnt;
  logic            preconn;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  slvport_arb #(.NM(NM), .PW(PW), .SLW(SLW), .FXW(FXW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .undef_i(undef), .beat_i(beat),
    .last_i(lst), .prio_i(prio), .ulbt_i(ulbt), .slot_lim_i(slot_lim),
    .park_mode_i(pmode), .park_fixed_i(pfix), .gnt_o(gnt), .preconn_o(preconn)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_gnt(input logic [NM-1:0] exp, input string tag);
    chk(gnt === exp, tag, int'(gnt), int'(exp));
  endtask

  function automatic int pick(input logic [NM-1:0] m, input logic [NM*PW-1:0] pr,
                              input int lastg);
    int top = 0;
    for (int i = 0; i < NM; i++)
      if (m[i] && int'(pr[i*PW +: PW]) > top) top = int'(pr[i*PW +: PW]);
    for (int k = 1; k <= NM; k++) begin
      int idx = (lastg + k) % NM;
      if (m[idx] && int'(pr[idx*PW +: PW]) == top) return idx;
    end
    return -1;
  endfunction

  task automatic go_idle;
    req = '0; beat = '0; lst = '0; undef = '0;
    tick;
  endtask

  // master 0 owns, master 1 waits with equal priority; returns after switch
  task automatic run_tenure(input int len, input string tag);
    req = 4'b0001; tick;
    chk_gnt(4'b0001, tag);
    req = 4'b0011;
    for (int j = 1; j < len; j++) begin
      tick;
      chk_gnt(4'b0001, tag);
    end
    tick;
    chk_gnt(4'b0010, tag);
    go_idle;
  endtask

  initial begin
    int lastg;
    rst_n = 1'b0; req = '0; undef = '0; beat = '0; lst = '0;
    prio = '0; ulbt = '0; slot_lim = '0; pmode = 2'd0; pfix = '0;
    repeat (3) @(posedge clk);
    #1;
    chk_gnt('0, "R1 reset grant");
    chk(preconn == 1'b0, "R1 reset preconn", int'(preconn), 0);
    rst_n = 1'b1;
    tick;
    chk_gnt('0, "R1 after reset");

    // R3 R4 R11: every priority set against every request mask
    lastg = NM - 1;
    for (int p = 0; p < 256; p++) begin
      for (int m = 1; m < 16; m++) begin
        int e;
        prio = p[7:0];
        req  = m[3:0];
        tick;
        e = pick(m[3:0], p[7:0], lastg);
        chk_gnt(4'b1 << e, "R3/R4 priority pick");
        lastg = e;
        req = '0;
        tick;
        chk_gnt('0, "R11 idle disconnect");
      end
    end

    // R5 R6 R7: chunked undefined-length bursts, equal priorities
    prio = '0;
    for (int c = 0; c < 8; c++) begin
      int len;
      len  = (c == 0) ? 256 : (c == 1) ? 1 : (1 << c);
      ulbt = {4{c[2:0]}};
      undef = 4'b0001; beat = 4'b0001;
      run_tenure(len, (c == 0) ? "R7 unlimited 1KB" : (c == 1) ? "R5 single" : "R6 chunk");
    end

    // R10: chunk end with no contender keeps grant
    ulbt = {4{3'd2}};
    req = 4'b0001; tick;
    undef = 4'b0001; beat = 4'b0001;
    for (int j = 0; j < 12; j++) begin
      tick;
      chk_gnt(4'b0001, "R10 keep grant");
    end
    go_idle;

    // R8: defined burst ignores chunk code, ends on last
    ulbt = {4{3'd2}};
    req = 4'b0001; tick;
    req = 4'b0011; beat = 4'b0001; undef = '0;
    for (int j = 0; j < 40; j++) tick;
    chk_gnt(4'b0001, "R8 defined burst held");
    lst = 4'b0001;
    tick;
    chk_gnt(4'b0010, "R8 last ends burst");
    go_idle;

    // R9: slot limit
    ulbt = '0;
    foreach (slot_lim_vals[i]) begin
      slot_lim = SLW'(slot_lim_vals[i]);
      run_tenure(slot_lim_vals[i], "R9 slot limit");
    end
    slot_lim = '0;
    req = 4'b0001; tick;
    req = 4'b0011;
    for (int j = 0; j < 300; j++) tick;
    chk_gnt(4'b0001, "R9 limit off");
    go_idle;

    // R11: one cycle latency when disconnected
    pmode = 2'd0;
    req = 4'b0100; #1;
    chk_gnt('0, "R11 not yet");
    tick;
    chk_gnt(4'b0100, "R11 granted next");

    // R12 R14: park on last
    pmode = 2'd1;
    req = '0; tick;
    chk_gnt(4'b0100, "R12 park last");
    chk(preconn == 1'b1, "R14 preconn parked", int'(preconn), 1);
    tick;
    chk_gnt(4'b0100, "R12 park last hold");
    req = 4'b0100; #1;
    chk_gnt(4'b0100, "R12 same cycle");
    chk(preconn == 1'b0, "R14 preconn requesting", int'(preconn), 0);
    tick;
    req = '0; tick;
    req = 4'b0010; tick;
    chk_gnt(4'b0010, "R12 other master takes over");
    req = '0; tick;
    chk_gnt(4'b0010, "R12 new last");

    // R13: fixed parking
    pmode = 2'd2; pfix = 4'd3;
    tick;
    chk_gnt(4'b1000, "R13 fixed park");
    chk(preconn == 1'b1, "R14 preconn fixed", int'(preconn), 1);
    req = 4'b1000; #1;
    chk_gnt(4'b1000, "R13 fixed same cycle");
    tick;
    req = '0; pfix = 4'd9;
    tick;
    chk_gnt('0, "R13 fixed out of range");
    pfix = 4'd0;
    tick;
    chk_gnt(4'b0001, "R13 fixed zero");
    pmode = 2'd3;
    tick;
    chk_gnt('0, "R11 reserved mode");
    chk(preconn == 1'b0, "R14 preconn none", int'(preconn), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  int slot_lim_vals [4] = '{1, 2, 5, 9};

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule